// File: doc/BRIEF.md
# LF tag downlink gap encoder

This block sends commands to a 125 kHz proximity tag by switching the reader carrier on and off. A command opens with a field-off lead gap. Each command bit is a field-on mark followed by a fixed field-off space, and the length of the mark decides whether the bit is a 0 or a 1. After the last space the field is switched on for a tail window. That window is a short settle period before a reply is received, or a long hold while the tag programs its memory or starts transmitting. All durations are counted in ticks of a 1 µs strobe. The defaults are the nominal values, and they can be changed to compensate for antenna fall time.

A requester presents one command on a valid/ready handshake. The command carries an operation code, a page bit, a password-enable flag, a 32-bit password, 32-bit data and an 8-bit block selector. The FSM has five states. IDLE waits for a request. LEAD holds the field off for the start gap. MARK holds the field on for one bit. SPACE holds the field off between bits. TAIL holds the field on for the settle or hold window.

The transitions are as follows. IDLE→LEAD on an accepted request. LEAD→MARK when the start gap expires. MARK→SPACE when the mark expires. SPACE→MARK when bits remain, or SPACE→TAIL after the last bit. TAIL→IDLE when the window expires, which also pulses `done`. In IDLE the field level is the one left behind by the previous command.

Top module: `lf_gap_encoder`

## Requirements
- R1: After a request is accepted, `field_en` is low for exactly T_START ticks (default 248) before the first bit mark.
- R2: A 0 bit is a mark of T_ZERO ticks (default 144) and a 1 bit is a mark of T_ONE ticks (default 400). Every mark is followed by a space of T_GAP ticks (default 160) with the field low.
- R3: Operation code 2'b01 (block write) sends these bits in order: 1; the page bit; the 32 password bits MSB first, only when password enable is 1; a 0 lock bit; the 32 data bits MSB first; the low 3 block bits MSB first. The field is then on for T_HOLD ticks (default 20000).
- R4: Operation code 2'b00 (reset) sends the bits 0, 0 and then holds the field on for T_SETTLE ticks (default 416).
- R5: Operation code 2'b10 (read) sends these bits in order: 1; the page bit; the optional 32-bit password MSB first; a 0 separator; the low 3 bits of the block selector MSB first. It then holds the field on for T_SETTLE ticks.
- R6: A read whose block selector is 8'hFF sends no address bits. Its frame ends at the separator bit.
- R7: Operation code 2'b11 (wake-up) sends 1, 0 and all 32 password bits MSB first, ignoring the page bit and the password-enable flag. It then holds the field on for T_HOLD ticks.
- R8: `req_ready` is high only in IDLE. A request presented while `busy` is high has no effect on the field sequence.
- R9: `busy` rises on the clock edge that accepts a request. `done` is a single-cycle pulse on the edge where the tail window ends, and `busy` falls on that same edge.
- R10: After reset `field_en` and `busy` are low and `req_ready` is high. After `done` the field stays high for reset, read and wake-up, and returns low after a write. It then holds that level until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Encoder idle, request will be taken |
| req_op | input | 2 | 00 reset, 01 write, 10 read, 11 wake-up |
| req_page | input | 1 | Page select bit |
| req_pwd_en | input | 1 | Send password (write/read) |
| req_pwd | input | 32 | Password |
| req_data | input | 32 | Write data |
| req_block | input | 8 | Block selector; 8'hFF on read selects register read |
| field_en | output | 1 | Carrier enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | Final field-on window elapsed (one cycle) |

## Verification
Any error in the frame bit register, the bits-left counter or the state register changes the length of a field-on mark or the number of marks. This shows at `field_en` within one bit time of the bad bit. A wrong tick count in the duration counter moves a field edge by at least one tick. A wrong parked level or a late `done` is visible on the first idle cycle after the tail window. The reference model predicts `field_en`, `busy`, `done` and `req_ready` for every clock. Each of these faults is therefore reported within a few microseconds of where it occurs.

// File: rtl/lfge_pkg.sv
package lfge_pkg;

    typedef enum logic [1:0] {
        CMD_RESET = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WAKE  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_MARK,
        S_SPACE,
        S_TAIL
    } state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lfge_frame_builder.sv
module lfge_frame_builder
    import lfge_pkg::*;
#(
    parameter int unsigned PW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned BW = 8,
    parameter int unsigned AW = 3,
    localparam int unsigned FW = 2 + PW + 1 + DW + AW,
    localparam int unsigned LW = $clog2(FW + 1)
) (
    input  cmd_e              op,
    input  logic              page,
    input  logic              pwd_en,
    input  logic [PW-1:0]     pwd,
    input  logic [DW-1:0]     data,
    input  logic [BW-1:0]     blk,
    output logic [FW-1:0]     frame,
    output logic [LW-1:0]     len
);

    logic [FW-1:0] acc;
    logic [LW-1:0] n;
    logic          regsel;

    assign regsel = (blk == {BW{1'b1}});

    always_comb begin
        acc = '0;
        n   = '0;
        unique case (op)
            CMD_RESET: begin
                acc = '0;
                n   = LW'(2);
            end
            CMD_WAKE: begin
                acc = FW'(2'b10);
                n   = LW'(2);
                acc = (acc << PW) | FW'(pwd);
                n   = n + LW'(PW);
            end
            CMD_WRITE: begin
                acc = FW'({1'b1, page});
                n   = LW'(2);
                if (pwd_en) begin
                    acc = (acc << PW) | FW'(pwd);
                    n   = n + LW'(PW);
                end
                acc = acc << 1;
                n   = n + LW'(1);
                acc = (acc << DW) | FW'(data);
                n   = n + LW'(DW);
                acc = (acc << AW) | FW'(blk[AW-1:0]);
                n   = n + LW'(AW);
            end
            CMD_READ: begin
                acc = FW'({1'b1, page});
                n   = LW'(2);
                if (pwd_en) begin
                    acc = (acc << PW) | FW'(pwd);
                    n   = n + LW'(PW);
                end
                acc = acc << 1;
                n   = n + LW'(1);
                if (!regsel) begin
                    acc = (acc << AW) | FW'(blk[AW-1:0]);
                    n   = n + LW'(AW);
                end
            end
            default: begin
                acc = '0;
                n   = LW'(2);
            end
        endcase
        frame = acc << (LW'(FW) - n);
        len   = n;
    end

endmodule

// File: rtl/lfge_seg_timer.sv
module lfge_seg_timer #(
    parameter int unsigned CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    assign expire = tick && (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/lf_gap_encoder.sv
module lf_gap_encoder
    import lfge_pkg::*;
#(
    parameter int unsigned T_START  = 248,
    parameter int unsigned T_GAP    = 160,
    parameter int unsigned T_ZERO   = 144,
    parameter int unsigned T_ONE    = 400,
    parameter int unsigned T_SETTLE = 416,
    parameter int unsigned T_HOLD   = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_us,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic        req_page,
    input  logic        req_pwd_en,
    input  logic [31:0] req_pwd,
    input  logic [31:0] req_data,
    input  logic [7:0]  req_block,
    output logic        field_en,
    output logic        busy,
    output logic        done
);

    localparam int unsigned PW   = 32;
    localparam int unsigned DW   = 32;
    localparam int unsigned BW   = 8;
    localparam int unsigned AW   = 3;
    localparam int unsigned FW   = 2 + PW + 1 + DW + AW;
    localparam int unsigned LW   = $clog2(FW + 1);
    localparam int unsigned MAXD = umax(umax(umax(T_START, T_GAP), umax(T_ZERO, T_ONE)),
                                        umax(T_SETTLE, T_HOLD));
    localparam int unsigned CW   = $clog2(MAXD + 1);

    state_e        state_q, state_d;
    cmd_e          op_q;
    logic [FW-1:0] frm_q;
    logic [LW-1:0] left_q;
    logic          park_q;
    logic          done_q;

    logic [FW-1:0] frame_w;
    logic [LW-1:0] len_w;
    logic          load;
    logic [CW-1:0] load_val;
    logic          expire;
    logic          capture;
    logic          shift;
    logic          fin;

    lfge_frame_builder #(
        .PW (PW),
        .DW (DW),
        .BW (BW),
        .AW (AW)
    ) u_frame (
        .op     (cmd_e'(req_op)),
        .page   (req_page),
        .pwd_en (req_pwd_en),
        .pwd    (req_pwd),
        .data   (req_data),
        .blk    (req_block),
        .frame  (frame_w),
        .len    (len_w)
    );

    lfge_seg_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick_us),
        .expire   (expire)
    );

    function automatic logic [CW-1:0] mark_len(input logic b);
        return b ? CW'(T_ONE) : CW'(T_ZERO);
    endfunction

    // next-state and segment loading
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        shift    = 1'b0;
        fin      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    capture  = 1'b1;
                    state_d  = S_LEAD;
                    load     = 1'b1;
                    load_val = CW'(T_START);
                end
            end
            S_LEAD: begin
                if (expire) begin
                    state_d  = S_MARK;
                    load     = 1'b1;
                    load_val = mark_len(frm_q[FW-1]);
                end
            end
            S_MARK: begin
                if (expire) begin
                    state_d  = S_SPACE;
                    load     = 1'b1;
                    load_val = CW'(T_GAP);
                end
            end
            S_SPACE: begin
                if (expire) begin
                    load = 1'b1;
                    if (left_q == LW'(1)) begin
                        state_d  = S_TAIL;
                        load_val = ((op_q == CMD_WRITE) || (op_q == CMD_WAKE))
                                   ? CW'(T_HOLD) : CW'(T_SETTLE);
                    end else begin
                        state_d  = S_MARK;
                        shift    = 1'b1;
                        load_val = mark_len(frm_q[FW-2]);
                    end
                end
            end
            S_TAIL: begin
                if (expire) begin
                    state_d = S_IDLE;
                    fin     = 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= CMD_RESET;
            frm_q   <= '0;
            left_q  <= '0;
            park_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
            if (capture) begin
                frm_q  <= frame_w;
                left_q <= len_w;
                op_q   <= cmd_e'(req_op);
                park_q <= (cmd_e'(req_op) != CMD_WRITE);
            end else if (shift) begin
                frm_q  <= frm_q << 1;
                left_q <= left_q - LW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_IDLE: begin
                field_en  = park_q;
                busy      = 1'b0;
                req_ready = 1'b1;
            end
            S_MARK, S_TAIL: begin
                field_en  = 1'b1;
                busy      = 1'b1;
                req_ready = 1'b0;
            end
            default: begin
                field_en  = 1'b0;
                busy      = 1'b1;
                req_ready = 1'b0;
            end
        endcase
        done = done_q;
    end

endmodule

// File: rtl/lfge_checker.sv
module lfge_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_op,
    input logic       busy,
    input logic       done,
    input logic       field_en
);

    logic wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            wr_q <= (req_op == 2'b01);
        end
    end

    p_lead_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !field_en);

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_write_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_q) |-> !field_en);

    p_other_lit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_q) |-> field_en);

    p_idle_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(field_en));

endmodule

bind lf_gap_encoder lfge_checker u_lfge_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .busy      (busy),
    .done      (done),
    .field_en  (field_en)
);

// File: tb/tb_lf_gap_encoder.sv
module tb_lf_gap_encoder;

    localparam int TS   = 5;
    localparam int TG   = 3;
    localparam int TZ   = 2;
    localparam int TO   = 4;
    localparam int TSET = 6;
    localparam int THLD = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic        req_page = 1'b0;
    logic        req_pwd_en = 1'b0;
    logic [31:0] req_pwd = '0;
    logic [31:0] req_data = '0;
    logic [7:0]  req_block = '0;
    logic        field_en;
    logic        busy;
    logic        done;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int wd = 0;
    string tag = "R10";

    always #10 clk = ~clk;

    lf_gap_encoder #(
        .T_START  (TS),
        .T_GAP    (TG),
        .T_ZERO   (TZ),
        .T_ONE    (TO),
        .T_SETTLE (TSET),
        .T_HOLD   (THLD)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_us    (tick_us),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_page   (req_page),
        .req_pwd_en (req_pwd_en),
        .req_pwd    (req_pwd),
        .req_data   (req_data),
        .req_block  (req_block),
        .field_en   (field_en),
        .busy       (busy),
        .done       (done)
    );

    // irregular microsecond strobe
    always @(negedge clk) begin
        cyc = cyc + 1;
        tick_us = (cyc % 3) != 0;
    end

    // ---------------- reference model ----------------
    int q_lvl[$];
    int q_dur[$];
    bit m_busy = 0;
    bit m_done = 0;
    bit m_field = 0;
    bit m_park = 0;
    int m_rem = 0;

    function automatic void seg(int lvl, int dur);
        q_lvl.push_back(lvl);
        q_dur.push_back(dur);
    endfunction

    function automatic void sbit(bit b);
        seg(1, b ? TO : TZ);
        seg(0, TG);
    endfunction

    function automatic void sword(logic [31:0] w, int nb);
        for (int i = nb - 1; i >= 0; i--) sbit(w[i]);
    endfunction

    function automatic void build(logic [1:0] op, bit pg, bit pen, logic [31:0] pw,
                                  logic [31:0] dt, logic [7:0] bk);
        q_lvl.delete();
        q_dur.delete();
        seg(0, TS);
        case (op)
            2'b00: begin sbit(0); sbit(0); seg(1, TSET); end
            2'b01: begin
                sbit(1); sbit(pg);
                if (pen) sword(pw, 32);
                sbit(0);
                sword(dt, 32);
                sword({29'd0, bk[2:0]}, 3);
                seg(1, THLD);
            end
            2'b10: begin
                sbit(1); sbit(pg);
                if (pen) sword(pw, 32);
                sbit(0);
                if (bk != 8'hFF) sword({29'd0, bk[2:0]}, 3);
                seg(1, TSET);
            end
            default: begin
                sbit(1); sbit(0);
                sword(pw, 32);
                seg(1, THLD);
            end
        endcase
    endfunction

    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_field = 0; m_park = 0; m_rem = 0;
            q_lvl.delete(); q_dur.delete();
        end else if (m_busy) begin
            if (tick_us) begin
                if (m_rem == 1) begin
                    if (q_lvl.size() == 0) begin
                        m_busy = 0; m_done = 1; m_field = m_park;
                    end else begin
                        m_field = q_lvl.pop_front() != 0;
                        m_rem = q_dur.pop_front();
                    end
                end else begin
                    m_rem = m_rem - 1;
                end
            end
        end else if (req_valid) begin
            build(req_op, req_page, req_pwd_en, req_pwd, req_data, req_block);
            m_field = q_lvl.pop_front() != 0;
            m_rem = q_dur.pop_front();
            m_busy = 1;
            m_park = (req_op != 2'b01);
        end
    end

    // per-clock comparison (R9 busy/done timing, R10 parked level, plus the active tag)
    always @(negedge clk) begin
        if (rst_n) begin
            vectors = vectors + 1;
            if (field_en !== m_field || busy !== m_busy || done !== m_done
                || req_ready !== !m_busy) begin
                miscompares = miscompares + 1;
                $display("FAIL %s (R9/R10) at cycle %0d: field/busy/done/ready got %b%b%b%b exp %b%b%b%b",
                         tag, cyc, field_en, busy, done, req_ready,
                         m_field, m_busy, m_done, !m_busy);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic send(input logic [1:0] op, input bit pg, input bit pen,
                        input logic [31:0] pw, input logic [31:0] dt,
                        input logic [7:0] bk, input string t);
        while (m_busy) @(negedge clk);
        @(negedge clk);
        tag = t;
        req_op = op; req_page = pg; req_pwd_en = pen;
        req_pwd = pw; req_data = dt; req_block = bk;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (m_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R10
        vectors = vectors + 1;
        if (field_en !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || req_ready !== 1'b1) begin
            miscompares = miscompares + 1;
            $display("FAIL R10 reset state: got %b%b%b%b exp 0001",
                     field_en, busy, done, req_ready);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(2'b00, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h07, "R1 R2 R4");
        send(2'b01, 1'b0, 1'b0, 32'h0, 32'hA5C3_0F96, 8'h05, "R2 R3");
        send(2'b01, 1'b1, 1'b1, 32'h8000_0001, 32'h1234_5678, 8'h02, "R3");
        send(2'b10, 1'b0, 1'b0, 32'h0, 32'h0, 8'h06, "R5");
        send(2'b10, 1'b1, 1'b0, 32'h0, 32'h0, 8'h2D, "R5");
        send(2'b10, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0, 8'h01, "R5");
        send(2'b10, 1'b1, 1'b0, 32'h0, 32'h0, 8'hFF, "R6");
        send(2'b11, 1'b1, 1'b0, 32'hC001_D00D, 32'h0, 8'h03, "R7");

        // R8: request presented while busy is ignored
        while (m_busy) @(negedge clk);
        @(negedge clk);
        tag = "R8";
        req_op = 2'b10; req_page = 1'b0; req_pwd_en = 1'b0; req_block = 8'h04;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        req_op = 2'b01; req_data = 32'hFFFF_FFFF; req_block = 8'h00;
        req_valid = 1'b1;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        while (m_busy) @(negedge clk);
        repeat (6) @(negedge clk);

        // back-to-back write then reset: write parks low, reset parks high (R10)
        send(2'b01, 1'b0, 1'b0, 32'h0, 32'h0000_0001, 8'h07, "R10");
        send(2'b00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule